// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor talk to Ethernet PHYs over the two-wire management bus. Software programs a small bank of 32-bit registers through a simple register port (byte address, write enable, write data, combinational read data). It selects the frame clause and the MDC divider, loads the PHY address and the register or device number, loads a 16-bit value, and then writes a command word. The block shifts out one complete management frame on MDIO, clocked by an MDC it derives from the system clock. On reads it releases the line and captures the PHY's reply.

A busy flag in the command register stays set from the accepted start until the frame is over. Clause 45 accesses take two frames issued by software. The first is an address frame, whose 16-bit payload comes from the write-data register. The second is a write or read frame. The same two-bit access code means different operations depending on the clause bit.

The frame engine is a three-state machine. ENG_IDLE moves to ENG_SHIFT on an accepted start. ENG_SHIFT stays in place and emits one bit per MDC rising edge. ENG_SHIFT moves to ENG_TAIL on the rising edge after the last bit, where the final read bit is captured and the line is released. ENG_TAIL returns to ENG_IDLE on the next MDC falling edge, which also clears busy.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the registers read as follows: mode (offset 0x40) reads 0x000000FF, address (0x44) reads 0, write data (0x48) reads 0, read data (0x4C) reads 0 and command (0x50) reads 0.
- R2: While a frame runs, MDC has a period of (divider + 1) system clocks, where the divider is mode bits 7:0. A divider of 0 behaves as 1. MDC is low whenever no frame runs.
- R3: Writing the command register with bit 8 set and a valid code in bits 1:0 starts a frame. Command bit 16 (busy) reads 1 from the next cycle until the frame is over.
- R4: With mode bit 8 clear (Clause 22), code 0 sends a read frame (start 01, opcode 10) and code 1 sends a write frame (start 01, opcode 01). Codes 2 and 3 start nothing.
- R5: With mode bit 8 set (Clause 45), code 0 sends an address frame (start 00, opcode 00, payload from write data), code 1 sends a write frame (00, 01) and code 2 sends a read frame (00, 11). Code 3 starts nothing.
- R6: Every frame is sent MSB first in this order: 32 ones, start, opcode, 5-bit PHY address (address bits 12:8), 5-bit register or device field (address bits 4:0), turnaround, and 16 data bits. On non-read frames the turnaround is 10 and the output enable is high for all 64 bits.
- R7: On read frames the line is released (output enable low) for the turnaround and data bits. The 16 reply bits are sampled on MDC rising edges and appear in read-data bits 15:0 before busy clears.
- R8: MDIO output changes only at MDC rising edges. A frame lasts 65 MDC cycles. The output enable is low once the frame ends.
- R9: A start written while busy is 1 is ignored, and no second frame follows.
- R10: Writes to the mode, address and write-data registers during a frame do not change that frame's bits or its MDC period.
- R11: The following register fields read back as written, with all other bits reading 0: mode bits 12, 8 and 7:0; address bits 12:8 and 4:0; write-data bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data sampled value |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, an 8-bit divider field and a divide-by-256 reset value. One frame therefore runs at the slow reset divider, and reprogramming the mode register then gives divide-by-2 (including the clamped zero setting) up to divide-by-7. That range covers the edge case where the MDC high and low phases are a single clock each, while the random runs stay short. With the full 32-bit preamble, each captured frame can be compared bit for bit with a real 64-bit management frame in both clauses.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam logic [7:0] OFS_MODE = 8'h40;
    localparam logic [7:0] OFS_ADDR = 8'h44;
    localparam logic [7:0] OFS_WDAT = 8'h48;
    localparam logic [7:0] OFS_RDAT = 8'h4C;
    localparam logic [7:0] OFS_CMD  = 8'h50;

    localparam int BIT_CLAUSE  = 8;
    localparam int BIT_MDCMODE = 12;
    localparam int BIT_START   = 8;
    localparam int BIT_BUSY    = 16;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_TAIL
    } eng_state_t;

    typedef struct packed {
        logic        c45;
        logic [1:0]  code;
        logic [4:0]  phy;
        logic [4:0]  dev;
        logic [15:0] data;
    } frame_req_t;

    function automatic logic code_ok(input logic c45, input logic [1:0] code);
        return c45 ? (code != 2'd3) : (code[1] == 1'b0);
    endfunction

    function automatic logic code_is_read(input logic c45, input logic [1:0] code);
        return c45 ? (code == 2'd2) : (code == 2'd0);
    endfunction

    // start and opcode bits, four of them, sent right after the preamble
    function automatic logic [3:0] start_opcode(input logic c45, input logic [1:0] code);
        logic [3:0] so;
        if (!c45) begin
            so = code[0] ? 4'b0101 : 4'b0110;
        end else begin
            unique case (code)
                2'd0:    so = 4'b0000;
                2'd1:    so = 4'b0001;
                default: so = 4'b0011;
            endcase
        end
        return so;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_p_o,
    output logic             fall_p_o
);

    logic [DIV_W-1:0] lim;
    logic [DIV_W:0]   lim_p1;
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;

    always_comb begin
        lim     = (div_i == '0) ? DIV_W'(1) : div_i;
        lim_p1  = {1'b0, lim} + (DIV_W+1)'(1);
        half_m1 = lim_p1[DIV_W:1] - DIV_W'(1);
    end

    assign rise_p_o = run_i && (cnt_q == lim);
    assign fall_p_o = run_i && (cnt_q != lim) && mdc_q && (cnt_q == half_m1);
    assign mdc_o    = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q <= lim;
            mdc_q <= 1'b0;
        end else if (cnt_q == lim) begin
            cnt_q <= '0;
            mdc_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            if (mdc_q && (cnt_q == half_m1)) begin
                mdc_q <= 1'b0;
            end
        end
    end

    // R2: two rising edges of MDC are never on adjacent system clocks
    p_rise_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_p_o |=> !rise_p_o);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DIV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  frame_req_t       req_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rise_p_i,
    input  logic             fall_p_i,
    input  logic             mdio_i,
    output logic             busy_o,
    output logic [DIV_W-1:0] div_o,
    output logic             mdio_o,
    output logic             mdio_oe_o,
    output logic [15:0]      rd_data_o
);

    localparam int FRAME_BITS = PRE_LEN + 32;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] TA_CNT   = CNT_W'(PRE_LEN + 14);
    localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(PRE_LEN + 16);

    eng_state_t            state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q;
    logic [FRAME_BITS-1:0] frame_w;
    logic [CNT_W-1:0]      bit_cnt_q;
    logic                  is_read_q;
    logic                  req_rd;
    logic [DIV_W-1:0]      div_q;
    logic                  mdio_o_q;
    logic                  oe_q;
    logic [15:0]           rd_sh_q;
    logic [15:0]           rd_hold_q;

    always_comb begin
        req_rd  = code_is_read(req_i.c45, req_i.code);
        frame_w = {{PRE_LEN{1'b1}},
                   start_opcode(req_i.c45, req_i.code),
                   req_i.phy,
                   req_i.dev,
                   req_rd ? 2'b11 : 2'b10,
                   req_rd ? 16'hFFFF : req_i.data};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (start_i) state_d = ENG_SHIFT;
            ENG_SHIFT: if (rise_p_i && bit_cnt_q == LAST_CNT) state_d = ENG_TAIL;
            ENG_TAIL:  if (fall_p_i) state_d = ENG_IDLE;
            default:   state_d = ENG_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '1;
            bit_cnt_q <= '0;
            is_read_q <= 1'b0;
            div_q     <= '0;
            mdio_o_q  <= 1'b1;
            oe_q      <= 1'b0;
            rd_sh_q   <= '0;
            rd_hold_q <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        sh_q      <= frame_w;
                        bit_cnt_q <= '0;
                        is_read_q <= req_rd;
                        div_q     <= div_i;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_p_i) begin
                        if (is_read_q && bit_cnt_q > DATA_CNT) begin
                            rd_sh_q <= {rd_sh_q[14:0], mdio_i};
                        end
                        if (bit_cnt_q != LAST_CNT) begin
                            mdio_o_q  <= sh_q[FRAME_BITS-1];
                            sh_q      <= {sh_q[FRAME_BITS-2:0], 1'b1};
                            oe_q      <= !(is_read_q && bit_cnt_q >= TA_CNT);
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end else begin
                            mdio_o_q <= 1'b1;
                            oe_q     <= 1'b0;
                            if (is_read_q) begin
                                rd_hold_q <= {rd_sh_q[14:0], mdio_i};
                            end
                        end
                    end
                end
                ENG_TAIL: begin
                    oe_q <= 1'b0;
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end

    assign busy_o    = (state_q != ENG_IDLE);
    assign div_o     = div_q;
    assign mdio_o    = mdio_o_q;
    assign mdio_oe_o = oe_q;
    assign rd_data_o = rd_hold_q;

    // R8: the data output only moves on an MDC rising edge
    p_out_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_SHIFT && !rise_p_i) |=> $stable(mdio_o_q));

    // R10: the divider and frame kind captured at start stay fixed for the frame
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENG_IDLE) |=> ($stable(div_q) && $stable(is_read_q)));

    // R7: a read frame has the line released after the turnaround began
    p_read_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_SHIFT && is_read_q && bit_cnt_q > TA_CNT) |-> !oe_q);

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr_i,
    input  logic             we_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic             busy_i,
    input  logic [15:0]      rd_data_i,
    output logic             start_o,
    output frame_req_t       req_o,
    output logic [DIV_W-1:0] div_o
);

    logic             c45_q;
    logic             mdcmode_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       phy_q;
    logic [4:0]       dev_q;
    logic [15:0]      wd_q;
    logic [31:0]      mode_rd;
    logic [31:0]      addr_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c45_q     <= 1'b0;
            mdcmode_q <= 1'b0;
            div_q     <= DIV_RST;
            phy_q     <= '0;
            dev_q     <= '0;
            wd_q      <= '0;
        end else if (we_i) begin
            if (addr_i == OFS_MODE) begin
                div_q     <= wdata_i[DIV_W-1:0];
                c45_q     <= wdata_i[BIT_CLAUSE];
                mdcmode_q <= wdata_i[BIT_MDCMODE];
            end
            if (addr_i == OFS_ADDR) begin
                phy_q <= wdata_i[12:8];
                dev_q <= wdata_i[4:0];
            end
            if (addr_i == OFS_WDAT) begin
                wd_q <= wdata_i[15:0];
            end
        end
    end

    assign start_o = we_i && (addr_i == OFS_CMD) && wdata_i[BIT_START] && !busy_i
                     && code_ok(c45_q, wdata_i[1:0]);
    assign req_o   = '{c45: c45_q, code: wdata_i[1:0], phy: phy_q, dev: dev_q, data: wd_q};
    assign div_o   = div_q;

    always_comb begin
        mode_rd                 = '0;
        mode_rd[DIV_W-1:0]      = div_q;
        mode_rd[BIT_CLAUSE]     = c45_q;
        mode_rd[BIT_MDCMODE]    = mdcmode_q;
        addr_rd                 = '0;
        addr_rd[12:8]           = phy_q;
        addr_rd[4:0]            = dev_q;
        unique case (addr_i)
            OFS_MODE: rdata_o = mode_rd;
            OFS_ADDR: rdata_o = addr_rd;
            OFS_WDAT: rdata_o = {16'h0, wd_q};
            OFS_RDAT: rdata_o = {16'h0, rd_data_i};
            OFS_CMD:  rdata_o = {15'h0, busy_i, 16'h0};
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int               PRE_LEN = 32,
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic             start_w;
    frame_req_t       req_w;
    logic [DIV_W-1:0] div_reg_w;
    logic [DIV_W-1:0] div_run_w;
    logic             busy_w;
    logic [15:0]      rd_data_w;
    logic             rise_w;
    logic             fall_w;

    mdio_mgmt_regs #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr),
        .we_i      (reg_we),
        .wdata_i   (reg_wdata),
        .rdata_o   (reg_rdata),
        .busy_i    (busy_w),
        .rd_data_i (rd_data_w),
        .start_o   (start_w),
        .req_o     (req_w),
        .div_o     (div_reg_w)
    );

    mdio_frame_engine #(
        .PRE_LEN (PRE_LEN),
        .DIV_W   (DIV_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .req_i     (req_w),
        .div_i     (div_reg_w),
        .rise_p_i  (rise_w),
        .fall_p_i  (fall_w),
        .mdio_i    (mdio_i),
        .busy_o    (busy_w),
        .div_o     (div_run_w),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .rd_data_o (rd_data_w)
    );

    mdio_mdc_gen #(
        .DIV_W (DIV_W)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (busy_w),
        .div_i    (div_run_w),
        .mdc_o    (mdc),
        .rise_p_o (rise_w),
        .fall_p_o (fall_w)
    );

    // R2, R8: with no frame running, MDC is low and the line is released
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> (!mdc && !mdio_oe));

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

    localparam logic [7:0] A_MODE = 8'h40;
    localparam logic [7:0] A_ADDR = 8'h44;
    localparam logic [7:0] A_WDAT = 8'h48;
    localparam logic [7:0] A_RDAT = 8'h4C;
    localparam logic [7:0] A_CMD  = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_in)
    );

    // PHY responder: observes and drives mid-bit, on MDC falling edges
    logic [63:0] cap;
    logic [63:0] oe_cap;
    logic [15:0] resp_word = 16'h0;
    int          nidx = 0;

    always @(negedge mdc) begin
        if (nidx < 64) begin
            cap[63-nidx]    = mdio_oe ? mdio_o : 1'b1;
            oe_cap[63-nidx] = mdio_oe;
            mdio_in         = (nidx >= 48) ? resp_word[63-nidx] : 1'b1;
        end else begin
            mdio_in = 1'b1;
        end
        nidx = nidx + 1;
    end

    // MDC period monitor, sampled at falling system clock edges
    int  cyc = 0;
    int  last_rise = -1;
    int  pmin = 1000000;
    int  pmax = 0;
    logic mdc_prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mdc && !mdc_prev) begin
            if (last_rise >= 0) begin
                if (cyc - last_rise < pmin) pmin = cyc - last_rise;
                if (cyc - last_rise > pmax) pmax = cyc - last_rise;
            end
            last_rise = cyc;
        end
        mdc_prev = mdc;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do reg_rd(A_CMD, v); while (v[16]);
    endtask

    function automatic logic [63:0] exp_frame(input bit c45, input logic [1:0] code,
                                              input logic [4:0] phy, input logic [4:0] dev,
                                              input logic [15:0] d);
        logic [3:0] so;
        if (!c45) so = (code == 2'd0) ? 4'b0110 : 4'b0101;
        else if (code == 2'd0) so = 4'b0000;
        else if (code == 2'd1) so = 4'b0001;
        else so = 4'b0011;
        return {32'hFFFF_FFFF, so, phy, dev, 2'b10, d};
    endfunction

    function automatic bit is_rd(input bit c45, input logic [1:0] code);
        return c45 ? (code == 2'd2) : (code == 2'd0);
    endfunction

    // expected values of the frame in flight
    bit          e_c45;
    logic [1:0]  e_code;
    logic [63:0] e_frame;
    logic [15:0] e_resp;
    int          e_per;

    task automatic start_op(input bit c45, input logic [1:0] code, input logic [4:0] phy,
                            input logic [4:0] dev, input logic [15:0] d,
                            input logic [15:0] resp, input logic [7:0] div);
        logic [31:0] v;
        reg_wr(A_MODE, {23'h0, c45, div});
        reg_wr(A_ADDR, {19'h0, phy, 3'h0, dev});
        reg_wr(A_WDAT, {16'h0, d});
        e_c45     = c45;
        e_code    = code;
        e_frame   = exp_frame(c45, code, phy, dev, d);
        e_resp    = resp;
        e_per     = (div == 8'd0) ? 2 : int'(div) + 1;
        resp_word = resp;
        nidx      = 0;
        last_rise = -1;
        pmin      = 1000000;
        pmax      = 0;
        reg_wr(A_CMD, {23'h0, 1'b1, 6'h0, code});
        reg_rd(A_CMD, v);
        check(v[16] == 1'b1, "R3 busy after start", {63'h0, v[16]}, 64'h1);
    endtask

    task automatic finish_op();
        logic [31:0] v;
        wait_idle();
        if (is_rd(e_c45, e_code)) begin
            check(cap[63:18] == e_frame[63:18], "R7 read frame header", cap, e_frame);
            check(oe_cap == 64'hFFFF_FFFF_FFFC_0000, "R7 line released on read", oe_cap, 64'hFFFF_FFFF_FFFC_0000);
            reg_rd(A_RDAT, v);
            check(v == {16'h0, e_resp}, "R7 read data", {32'h0, v}, {48'h0, e_resp});
        end else begin
            check(cap == e_frame, e_c45 ? "R5 R6 clause 45 frame" : "R4 R6 clause 22 frame", cap, e_frame);
            check(oe_cap == 64'hFFFF_FFFF_FFFF_FFFF, "R6 driven throughout", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        check(nidx == 65, "R8 MDC cycles per frame", 64'(nidx), 64'd65);
        check(pmin == e_per && pmax == e_per, "R2 MDC period", 64'(pmax), 64'(e_per));
        @(negedge clk);
        check(!mdc && !mdio_oe, "R8 idle after frame", {62'h0, mdc, mdio_oe}, 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        reg_rd(A_MODE, v); check(v == 32'h0000_00FF, "R1 mode reset", 64'(v), 64'hFF);
        reg_rd(A_ADDR, v); check(v == 32'h0, "R1 address reset", 64'(v), 64'h0);
        reg_rd(A_WDAT, v); check(v == 32'h0, "R1 write data reset", 64'(v), 64'h0);
        reg_rd(A_RDAT, v); check(v == 32'h0, "R1 read data reset", 64'(v), 64'h0);
        reg_rd(A_CMD, v);  check(v == 32'h0, "R1 command reset", 64'(v), 64'h0);
        check(!mdc && !mdio_oe, "R2 MDC low at rest", {62'h0, mdc, mdio_oe}, 64'h0);

        // R2 reset divider: Clause 22 write at divide-by-256
        start_op(1'b0, 2'd1, 5'h11, 5'h04, 16'hBEEF, 16'h0, 8'hFF);
        finish_op();

        // R11 readback masks
        reg_wr(A_MODE, 32'hFFFF_FFFF); reg_rd(A_MODE, v);
        check(v == 32'h0000_11FF, "R11 mode readback", 64'(v), 64'h11FF);
        reg_wr(A_ADDR, 32'hFFFF_FFFF); reg_rd(A_ADDR, v);
        check(v == 32'h0000_1F1F, "R11 address readback", 64'(v), 64'h1F1F);
        reg_wr(A_WDAT, 32'hFFFF_FFFF); reg_rd(A_WDAT, v);
        check(v == 32'h0000_FFFF, "R11 write data readback", 64'(v), 64'hFFFF);

        // R2 divider 0 acts as 1
        start_op(1'b0, 2'd1, 5'h00, 5'h1F, 16'h0001, 16'h0, 8'h00);
        finish_op();
        // R4 Clause 22 read
        start_op(1'b0, 2'd0, 5'h1F, 5'h02, 16'h0, 16'h8001, 8'h03);
        finish_op();
        // R5 Clause 45 address, write, read sequence
        start_op(1'b1, 2'd0, 5'h03, 5'h07, 16'h1234, 16'h0, 8'h01);
        finish_op();
        start_op(1'b1, 2'd1, 5'h03, 5'h07, 16'hCAFE, 16'h0, 8'h01);
        finish_op();
        start_op(1'b1, 2'd2, 5'h03, 5'h07, 16'h0, 16'h5AA5, 8'h02);
        finish_op();

        // R4 R5 codes that start nothing
        reg_wr(A_MODE, 32'h0000_0003);
        nidx = 0;
        reg_wr(A_CMD, 32'h0000_0102); reg_rd(A_CMD, v);
        check(v[16] == 1'b0, "R4 clause 22 code 2 ignored", 64'(v), 64'h0);
        reg_wr(A_CMD, 32'h0000_0103); reg_rd(A_CMD, v);
        check(v[16] == 1'b0, "R4 clause 22 code 3 ignored", 64'(v), 64'h0);
        reg_wr(A_MODE, 32'h0000_0103);
        reg_wr(A_CMD, 32'h0000_0103); reg_rd(A_CMD, v);
        check(v[16] == 1'b0, "R5 clause 45 code 3 ignored", 64'(v), 64'h0);
        repeat (40) @(negedge clk);
        check(nidx == 0, "R4 R5 no MDC for bad code", 64'(nidx), 64'h0);

        // R9 R10 start and register writes during a frame
        start_op(1'b0, 2'd1, 5'h05, 5'h09, 16'hA5A5, 16'h0, 8'h03);
        repeat (40) @(negedge clk);
        reg_wr(A_MODE, 32'h0000_0101);
        reg_wr(A_ADDR, 32'h0000_1A1B);
        reg_wr(A_WDAT, 32'h0000_0F0F);
        reg_wr(A_CMD,  32'h0000_0101);
        finish_op();
        repeat (60) @(negedge clk);
        check(nidx == 65, "R9 no frame from start while busy", 64'(nidx), 64'd65);
        reg_rd(A_CMD, v);
        check(v[16] == 1'b0, "R9 busy stays clear", 64'(v), 64'h0);

        // random mix
        for (int k = 0; k < 25; k++) begin
            bit         c45;
            logic [1:0] code;
            c45  = 1'($urandom % 2);
            code = c45 ? 2'($urandom % 3) : 2'($urandom % 2);
            start_op(c45, code, 5'($urandom), 5'($urandom), 16'($urandom),
                     16'($urandom), 8'(1 + ($urandom % 6)));
            finish_op();
        end

        summary();
        $finish;
    end

endmodule